// File: doc/BRIEF.md
# Touchscreen Converter Serial Slave Front End

This block is the device-side serial port of a successive-approximation touchscreen converter. An external host drives a serial clock and an active-low select. While select is low, the block watches the data input for a start bit on each rising clock edge. Once it sees one, it takes in an eight-bit command. In the clock period after the last command bit, it raises a busy flag. It then shifts a result taken from a parallel sample port out on the data output, most significant bit first, launching each bit on a falling edge.

A command bit chooses between a twelve-bit result and a shortened eight-bit result. After each command, the block ignores the data input for a fixed number of clocks that depends on the mode. Once that holdoff has passed, it is armed again. A host that keeps select low can therefore send the next command while the previous result is still shifting out, and run conversions back to back without toggling select. Raising select stops everything and releases both outputs.

Top module: `tsc_serial_slave`

## Requirements
- R1: While select is low and the block is armed, a rising clock edge that samples the data input low is ignored. One that samples it high is taken as the start bit, which is command bit 7 and the first of eight command bits, MSB first.
- R2: The data output is low during the eight command cycles whenever no earlier result is still being shifted out.
- R3: In twelve-bit mode, counting the start edge as edge 1, the result MSB is valid at rising edge 10. The twelve bits follow MSB first and are then followed by zeros, so a full 24-clock cycle shows 9 zeros, 12 data bits and 3 zeros.
- R4: Command bit 3 selects the mode: 1 means eight-bit, 0 means twelve-bit. In eight-bit mode, only the upper eight bits of the sample are shifted out, on edges 10 to 17, and the output is low afterwards.
- R5: Busy is high for exactly the clock period between rising edges 8 and 9 and is low at every other time while select is low.
- R6: The sample port is captured on rising edge 8. Later changes on it do not alter the bits that are shifted out.
- R7: After command edge 8, the data input is ignored on the next 7 rising edges in twelve-bit mode and on the next 3 in eight-bit mode. A start bit is accepted on the edge after that, which gives a minimum cycle of 15 clocks in twelve-bit mode and 11 clocks in eight-bit mode.
- R8: A command accepted while a result is still shifting out is captured alongside it. The earlier result completes unchanged on the data output.
- R9: While select is high, both output enables are low and the data input is ignored. A rising select aborts any conversion, so no result bit or busy pulse from it appears in a later frame.
- R10: With select held low, each new start bit begins another full command, busy and result sequence, without a new select frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; high clears and releases the block |
| din | input | 1 | Serial command input, sampled on rising edges |
| sample | input | RES_W | Parallel conversion value, captured on command edge 8 |
| dout | output | 1 | Serial result data, launched on falling edges |
| dout_oe | output | 1 | Drive enable for dout |
| busy | output | 1 | Busy flag |
| busy_oe | output | 1 | Drive enable for busy |

## Verification
The assertions assume the host sends a start bit only once the block is armed again. Under that assumption, a new command cannot finish while an earlier result still has bits left to shift. They also assume the host keeps select low for a whole frame. The stimulus builds every frame from the holdoff rule, which keeps it within these limits: the data input is driven high throughout each holdoff window, and the next start bit is placed on the first edge at which the block is armed again. Frames mix modes and extra gaps of zero to three clocks, and one frame is cut short inside a result to exercise the abort path.

// File: rtl/tsc_serial_slave.sv
module tsc_serial_slave #(
  parameter int RES_W      = 12,
  parameter int CTL_W      = 8,
  parameter int SHORT_W    = 8,
  parameter int MODE_BIT   = 3,
  parameter int HOLD_LONG  = 7,
  parameter int HOLD_SHORT = 3
) (
  input  logic             dclk,
  input  logic             cs_n,
  input  logic             din,
  input  logic [RES_W-1:0] sample,
  output logic             dout,
  output logic             dout_oe,
  output logic             busy,
  output logic             busy_oe
);
  localparam int CW = $clog2(CTL_W);
  localparam int HW = $clog2(HOLD_LONG + 1);
  localparam int LW = $clog2(RES_W + 1);
  localparam int MODE_IDX = CTL_W - 1 - MODE_BIT;

  typedef enum logic [1:0] {ARM, CAP, HOLD} phase_t;

  phase_t           phase;
  logic [CW-1:0]    bcnt;
  logic [HW-1:0]    hold;
  logic             mode_c;
  logic             busy_q;
  logic [RES_W-1:0] samp_q;
  logic [RES_W-1:0] sh;
  logic [LW-1:0]    left;
  logic             dout_q;
  logic             mode_now;

  assign mode_now = (32'(bcnt) == MODE_IDX) ? din : mode_c;

  always_ff @(posedge dclk or posedge cs_n) begin
    if (cs_n) begin
      phase  <= ARM;
      bcnt   <= '0;
      hold   <= '0;
      mode_c <= 1'b0;
      busy_q <= 1'b0;
      samp_q <= '0;
    end else begin
      busy_q <= 1'b0;
      case (phase)
        ARM: if (din) begin
          phase <= CAP;
          bcnt  <= CW'(1);
        end
        CAP: begin
          bcnt <= bcnt + 1'b1;
          if (32'(bcnt) == MODE_IDX) mode_c <= din;
          if (32'(bcnt) == CTL_W - 1) begin
            phase  <= HOLD;
            bcnt   <= '0;
            busy_q <= 1'b1;
            samp_q <= sample;
            hold   <= mode_now ? HW'(HOLD_SHORT) : HW'(HOLD_LONG);
          end
        end
        default: begin
          hold <= hold - 1'b1;
          if (hold == HW'(1)) phase <= ARM;
        end
      endcase
    end
  end

  always_ff @(negedge dclk or posedge cs_n) begin
    if (cs_n) begin
      sh     <= '0;
      left   <= '0;
      dout_q <= 1'b0;
    end else if (busy_q) begin
      sh     <= samp_q;
      left   <= mode_c ? LW'(SHORT_W) : LW'(RES_W);
      dout_q <= 1'b0;
    end else if (left != '0) begin
      dout_q <= sh[RES_W-1];
      sh     <= {sh[RES_W-2:0], 1'b0};
      left   <= left - 1'b1;
    end else begin
      dout_q <= 1'b0;
    end
  end

  assign dout    = dout_q;
  assign busy    = busy_q;
  assign dout_oe = !cs_n;
  assign busy_oe = !cs_n;

  // R1
  idle_zero_chk: assert property (@(posedge dclk) disable iff (cs_n)
    (phase == ARM && !din) |=> phase == ARM);
  // R5
  busy_single_chk: assert property (@(posedge dclk) disable iff (cs_n)
    busy_q |=> !busy_q);
  // R2
  dout_quiet_chk: assert property (@(posedge dclk) disable iff (cs_n)
    (phase == CAP && left == '0 && $past(left) == '0) |-> !dout_q);
  // R7
  holdoff_chk: assert property (@(posedge dclk) disable iff (cs_n)
    (phase == HOLD && hold != HW'(1)) |=> phase == HOLD);
  // R8
  overlap_clear_chk: assert property (@(posedge dclk) disable iff (cs_n)
    (phase == CAP && 32'(bcnt) == CTL_W - 1) |-> left == '0);
endmodule

// File: tb/test_tsc_serial_slave.sv
module test_tsc_serial_slave;
  localparam int PERIOD = 10;
  localparam int N = 128;

  logic clk = 1'b0;
  logic cs_n = 1'b1;
  logic din = 1'b0;
  logic [11:0] sample = '0;
  logic dout, dout_oe, busy, busy_oe;

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic        din_a [N];
  logic [11:0] smp_a [N];
  logic        exp_d [N];
  logic        exp_b [N];
  string       td [N];
  string       tbz [N];
  int          len;

  tsc_serial_slave i_tsc_serial_slave (
    .dclk(clk), .cs_n(cs_n), .din(din), .sample(sample),
    .dout(dout), .dout_oe(dout_oe), .busy(busy), .busy_oe(busy_oe)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input logic act, input logic expv, input string tag, input int k);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: cycle %0d got %b expected %b", tag, k, act, expv);
    end
  endtask

  // Builds one frame of n conversions; mode select 0 = all twelve-bit,
  // 1 = all eight-bit, 2 = alternating; gap = extra clocks past the holdoff.
  task automatic build(input int n, input int msel, input int gap, input int seed, input int cut);
    int s = 2;
    int last = 0;
    for (int k = 0; k < N; k++) begin
      din_a[k] = 1'b0;
      smp_a[k] = 12'((k * 733 + seed * 97) & 'hFFF);
      exp_d[k] = 1'b0;
      exp_b[k] = 1'b0;
      td[k]    = "R1";
      tbz[k]   = "R5";
    end
    for (int c = 0; c < n; c++) begin
      int m = (msel == 2) ? (c & 1) : msel;
      int nb = m ? 8 : 12;
      int h = m ? 3 : 7;
      logic [11:0] v = 12'((c * 1237 + seed * 331 + 5) & 'hFFF);
      logic [7:0] w = {1'b1, 3'(c * 3), m[0], 3'(c + seed)};
      for (int b = 0; b < 8; b++) begin
        din_a[s+b] = w[7-b];
        if (td[s+b] == "R1") td[s+b] = "R2";
      end
      // R7: every holdoff edge carries a one that must not start a command
      for (int j = 1; j <= h; j++) din_a[s+7+j] = 1'b1;
      // R6: sample holds the value only on edge 8, noise elsewhere
      smp_a[s+7] = v;
      exp_b[s+8] = 1'b1;
      tbz[s+8] = (c > 0) ? "R10" : "R5";
      for (int i = 0; i < nb; i++) begin
        exp_d[s+9+i] = v[11-i];
        td[s+9+i] = (c > 0) ? "R8" : (m ? "R4" : "R3");
      end
      last = s;
      s = s + 8 + h + gap;
    end
    len = (n == 0) ? 30 : last + 26;
    if (cut > 0) len = cut;
  endtask

  task automatic play();
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      #(PERIOD/4);
      cs_n = 1'b0;
      din = din_a[k];
      sample = smp_a[k];
      #1;
      chk(dout, exp_d[k], td[k], k);
      chk(busy, exp_b[k], tbz[k], k);
      chk(dout_oe & busy_oe, 1'b1, "R9", k);
    end
    @(negedge clk);
    #(PERIOD/4);
    cs_n = 1'b1;
    din = 1'b1;
    #1;
    chk(dout_oe | busy_oe, 1'b0, "R9", -1);
    repeat (3) @(negedge clk);
    din = 1'b0;
  endtask

  initial begin
    #(PERIOD * 2 + 1);
    chk(dout_oe, 1'b0, "R9", 0);
    chk(busy_oe, 1'b0, "R9", 0);
    build(1, 0, 0, 1, 0); play();
    build(1, 1, 0, 2, 0); play();
    for (int g = 0; g < 4; g++)
      for (int ms = 0; ms < 3; ms++) begin
        build(4, ms, g, g * 3 + ms + 5, 0);
        play();
      end
    // R9: abort inside the result, then a quiet frame must show nothing
    build(1, 0, 0, 7, 14); play();
    build(0, 0, 0, 8, 0);
    for (int k = 0; k < N; k++) begin td[k] = "R9"; tbz[k] = "R9"; end
    play();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end
endmodule